// File: doc/BRIEF.md
# Sensor Sample Read Bank

This block is the read side of a three-axis acceleration sample bank. It keeps the most recent 14-bit X, Y and Z samples and presents each one as a high byte and a low byte. A byte-serial bus front end supplies a start address and then steps through the bytes one at a time. The front end, the sample producer and the other control registers sit outside this block.

A fast-read control shortens a burst to the three high bytes. A low byte can still be reached by addressing it directly. A FIFO control switches the bank into queue mode. In that mode a 32-deep queue of whole X/Y/Z sets stores every new sample. The first data address turns into a streaming port on the queue head, and the other data addresses read as zero. Each burst freezes its own copy of the sample set, so a burst never mixes two samples.

Top module: `accel_rd_bank`

## Requirements
- R1: A 14-bit two's-complement sample `d` is shown as a high byte `d[13:6]` and a low byte `{d[5:0], 2'b00}`.
- R2: With fast-read and FIFO mode both off, a burst that starts at address 1 returns X high, X low, Y high, Y low, Z high, Z low. The address then wraps from 6 to the status byte at address 0, and from there goes on to address 1.
- R3: With fast-read on and FIFO mode off, stepping from address 1 visits only the high-byte addresses 1, 3 and 5, and then wraps to 0.
- R4: With fast-read on, a burst that starts directly at a low-byte address (2, 4 or 6) returns that byte's real contents.
- R5: All bytes of one burst come from the sample set captured when the burst started, even if a new sample arrives during the burst.
- R6: In FIFO mode, a burst started at any address from 2 to 6 returns 0x00.
- R7: In FIFO mode, address 1 streams the bytes of the oldest queued set. It gives six bytes with fast-read off, or the three high bytes with fast-read on. After the last byte of a set, the next step removes that set from the queue and returns the first byte of the next set.
- R8: In FIFO mode, reading address 1 while the queue is empty returns 0x00.
- R9: The status byte at address 0 carries the queue fill level in bits 5:0 and an overflow flag in bit 7. A sample written into a full queue drops the oldest set and sets the flag. Reading the status byte clears the flag.
- R10: After reset, the data output is 0x00, the queue is empty and the overflow flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | New sample set present on smp_x/y/z |
| smp_x | input | 14 | X sample, two's complement |
| smp_y | input | 14 | Y sample, two's complement |
| smp_z | input | 14 | Z sample, two's complement |
| cfg_fast | input | 1 | Fast-read: auto-increment skips low bytes |
| cfg_fifo | input | 1 | FIFO mode: queue stores samples, address 1 streams queue head |
| rd_start | input | 1 | Begin a burst at rd_addr |
| rd_addr | input | 3 | Burst start address (0 status, 1..6 data) |
| rd_next | input | 1 | Step to the next byte of the burst |
| rd_data | output | 8 | Registered byte at the current burst position |

## Verification
The table-driven part reads full bursts over samples chosen to separate the two byte halves. It uses the largest positive value, the most negative value, minus one and alternating bit patterns, each with fast-read both off and on. A swapped byte half, a wrong shift or a missed skip therefore shows up as a wrong byte value. Directed tests start bursts at low-byte addresses, load a new sample in the middle of a burst, and fill the queue with numbered sets whose high bytes carry their index. A wrong pop point, a wrong drop order or a stale status level then gives a visibly different number.

// File: rtl/accel_rd_pkg.sv
package accel_rd_pkg;
  localparam int SMP_W = 14;

  typedef struct packed {
    logic [SMP_W-1:0] x;
    logic [SMP_W-1:0] y;
    logic [SMP_W-1:0] z;
  } trip_t;

  localparam int TRIP_W = 3 * SMP_W;

  // idx: 0/1 X high/low, 2/3 Y high/low, 4/5 Z high/low
  function automatic logic [7:0] pick_byte(trip_t t, logic [2:0] idx);
    logic [SMP_W-1:0] s;
    case (idx[2:1])
      2'd0:    s = t.x;
      2'd1:    s = t.y;
      default: s = t.z;
    endcase
    return idx[0] ? {s[5:0], 2'b00} : s[13:6];
  endfunction
endpackage

// File: rtl/accel_trip_fifo.sv
module accel_trip_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 42,
  localparam int PW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [W-1:0]  head2,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          drop
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic          full;

  function automatic logic [PW-1:0] inc(logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == LW'(DEPTH));
  assign empty = (level == '0);
  assign drop  = push && full && !pop;
  assign head  = mem[rptr];
  assign head2 = mem[inc(rptr)];

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= inc(wptr);
      if ((pop && !empty) || drop) rptr <= inc(rptr);
      if (push && !pop && !full) level <= level + 1'b1;
      else if (pop && !push && !empty) level <= level - 1'b1;
    end
  end

  p_level_bound_r9: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH));
  p_drop_full_r9: assert property (@(posedge clk) disable iff (rst)
    drop |=> full);
  p_pop_nonempty_r7: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/accel_addr_step.sv
module accel_addr_step (
  input  logic [2:0] cur,
  input  logic       fast,
  output logic [2:0] nxt
);
  always_comb begin
    nxt = cur + 3'd1;
    if (fast && nxt != 3'd0 && !nxt[0]) nxt = nxt + 3'd1;
    if (nxt == 3'd7) nxt = 3'd0;
  end

  always_comb begin
    p_step_range_r2: assert (nxt != 3'd7);
  end
endmodule

// File: rtl/accel_rd_bank.sv
module accel_rd_bank
  import accel_rd_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_x,
  input  logic [SMP_W-1:0] smp_y,
  input  logic [SMP_W-1:0] smp_z,
  input  logic             cfg_fast,
  input  logic             cfg_fifo,
  input  logic             rd_start,
  input  logic [2:0]       rd_addr,
  input  logic             rd_next,
  output logic [7:0]       rd_data
);
  trip_t smp_in, live, shadow, n_sh, head, head2, head_now;
  logic [TRIP_W-1:0] head_v, head2_v;
  logic [2:0] cur, bidx, step_addr, n_addr, n_idx;
  logic [LW-1:0] level;
  logic sh_valid, n_shv, ovf, empty, drop, push, pop, last, at_port, load;
  logic [7:0] stat, n_byte;

  assign smp_in   = '{x: smp_x, y: smp_y, z: smp_z};
  assign push     = smp_valid && cfg_fifo;
  assign head     = trip_t'(head_v);
  assign head2    = trip_t'(head2_v);
  assign head_now = drop ? head2 : head;
  assign at_port  = cfg_fifo && cur == 3'd1;
  assign last     = cfg_fast ? (bidx >= 3'd4) : (bidx == 3'd5);
  assign pop      = !rd_start && rd_next && at_port && last && sh_valid;

  accel_trip_fifo #(.DEPTH(DEPTH), .W(TRIP_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .wdata(TRIP_W'(smp_in)), .pop(pop),
    .head(head_v), .head2(head2_v), .level(level), .empty(empty), .drop(drop)
  );

  accel_addr_step u_step (.cur(cur), .fast(cfg_fast), .nxt(step_addr));

  always_comb begin
    n_addr = cur;
    n_idx  = bidx;
    n_sh   = shadow;
    n_shv  = sh_valid;
    load   = 1'b0;
    if (rd_start) begin
      n_addr = rd_addr;
      n_idx  = 3'd0;
      load   = 1'b1;
      n_sh   = cfg_fifo ? (empty ? '0 : head_now) : live;
      n_shv  = cfg_fifo && !empty;
    end else if (rd_next) begin
      if (at_port) begin
        if (last) begin
          n_idx = 3'd0;
          load  = 1'b1;
          if (sh_valid) begin
            if (level >= LW'(2)) n_sh = head2;
            else n_sh = push ? smp_in : '0;
            n_shv = (level >= LW'(2)) || push;
          end else begin
            n_sh  = empty ? '0 : head_now;
            n_shv = !empty;
          end
        end else begin
          n_idx = bidx + (cfg_fast ? 3'd2 : 3'd1);
        end
      end else begin
        n_addr = step_addr;
      end
    end
    if (drop && !load) n_shv = 1'b0;
  end

  always_comb begin
    stat    = 8'(level);
    stat[7] = ovf;
    if (n_addr == 3'd0)   n_byte = stat;
    else if (cfg_fifo)    n_byte = (n_addr == 3'd1) ? pick_byte(n_sh, n_idx) : 8'h00;
    else if (n_addr != 3'd7) n_byte = pick_byte(n_sh, n_addr - 3'd1);
    else                  n_byte = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live     <= '0;
      shadow   <= '0;
      sh_valid <= 1'b0;
      cur      <= '0;
      bidx     <= '0;
      ovf      <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (smp_valid) live <= smp_in;
      shadow   <= n_sh;
      sh_valid <= n_shv;
      cur      <= n_addr;
      bidx     <= n_idx;
      if (drop) ovf <= 1'b1;
      else if ((rd_start || rd_next) && n_addr == 3'd0) ovf <= 1'b0;
      if (rd_start || rd_next) rd_data <= n_byte;
    end
  end

  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!rd_start && !cfg_fifo) |=> $stable(shadow));
  p_fifo_gap_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg_fifo && rd_start && rd_addr >= 3'd2 && rd_addr <= 3'd6) |=> rd_data == 8'h00);
  p_fast_skip_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_next && !rd_start && cfg_fast && !cfg_fifo) |=> (cur == 3'd0 || cur[0]));
  p_ovf_flag_r9: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf);
endmodule

// File: tb/accel_rd_bank_test.sv
module accel_rd_bank_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic smp_valid = 1'b0, cfg_fast = 1'b0, cfg_fifo = 1'b0;
  logic rd_start = 1'b0, rd_next = 1'b0;
  logic [2:0] rd_addr = '0;
  logic [13:0] smp_x = '0, smp_y = '0, smp_z = '0;
  logic [7:0] rd_data;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  accel_rd_bank uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
    .smp_z(smp_z), .cfg_fast(cfg_fast), .cfg_fifo(cfg_fifo), .rd_start(rd_start),
    .rd_addr(rd_addr), .rd_next(rd_next), .rd_data(rd_data)
  );

  // {fast, x, y, z}
  localparam logic [42:0] VEC [4] = '{
    {1'b0, 14'h1FFF, 14'h2000, 14'h0001},
    {1'b1, 14'h3FFF, 14'h0040, 14'h2AAA},
    {1'b0, 14'h1555, 14'h0ABC, 14'h3F00},
    {1'b1, 14'h0000, 14'h1234, 14'h0FFF}
  };

  function automatic logic [7:0] hi(logic [13:0] v); return v[13:6]; endfunction
  function automatic logic [7:0] lo(logic [13:0] v); return {v[5:0], 2'b00}; endfunction
  function automatic logic [41:0] mk(int i);
    return {14'((i << 6) | 5), 14'((i + 8) << 6), 14'(((i + 16) << 6) | 63)};
  endfunction

  task automatic tick; @(posedge clk); @(negedge clk); endtask
  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%02h exp=%02h", tag, got, exp);
    end
  endtask
  task automatic load(logic [41:0] s);
    {smp_x, smp_y, smp_z} = s; smp_valid = 1'b1; tick(); smp_valid = 1'b0;
  endtask
  task automatic start(logic [2:0] a);
    rd_addr = a; rd_start = 1'b1; tick(); rd_start = 1'b0;
  endtask
  task automatic nxt; rd_next = 1'b1; tick(); rd_next = 1'b0; endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp [6];
    int n;
    tick(); tick(); tick();
    rst = 1'b0;
    chk("R10 data after reset", rd_data, 8'h00);
    start(3'd0);
    chk("R10 status after reset", rd_data, 8'h00);

    // table of bursts: R1 formatting, R2 normal order, R3 fast skip
    for (int i = 0; i < 4; i++) begin
      logic [13:0] x, y, z;
      {cfg_fast, x, y, z} = VEC[i];
      load({x, y, z});
      if (cfg_fast) begin
        exp[0] = hi(x); exp[1] = hi(y); exp[2] = hi(z); n = 3;
      end else begin
        exp[0] = hi(x); exp[1] = lo(x); exp[2] = hi(y);
        exp[3] = lo(y); exp[4] = hi(z); exp[5] = lo(z); n = 6;
      end
      start(3'd1);
      for (int k = 0; k < n; k++) begin
        chk(cfg_fast ? "R3 fast burst byte" : "R1 R2 burst byte", rd_data, exp[k]);
        nxt();
      end
      chk("R2 wrap to status", rd_data, 8'h00);
      nxt();
      chk("R2 wrap back to X high", rd_data, hi(x));
    end

    // R4: direct low-byte reads under fast-read
    cfg_fast = 1'b1;
    load({14'h2D5B, 14'h1ABC, 14'h3C3D});
    start(3'd2);
    chk("R4 direct X low", rd_data, lo(14'h2D5B));
    nxt();
    chk("R4 step from 2 to Y high", rd_data, hi(14'h1ABC));
    start(3'd6);
    chk("R4 direct Z low", rd_data, lo(14'h3C3D));
    nxt();
    chk("R3 step from 6 to status", rd_data, 8'h00);

    // R5: new sample mid-burst does not leak
    cfg_fast = 1'b0;
    load({14'h0111, 14'h0222, 14'h0333});
    start(3'd1);
    chk("R5 first byte", rd_data, hi(14'h0111));
    load({14'h3EEE, 14'h3DDD, 14'h3CCC});
    nxt();
    chk("R5 X low from old sample", rd_data, lo(14'h0111));
    nxt();
    chk("R5 Y high from old sample", rd_data, hi(14'h0222));
    start(3'd1);
    chk("R5 next burst sees new sample", rd_data, hi(14'h3EEE));

    // FIFO mode
    cfg_fifo = 1'b1;
    start(3'd1);
    chk("R8 empty FIFO reads zero", rd_data, 8'h00);
    start(3'd0);
    chk("R9 empty level", rd_data, 8'h00);
    load(mk(1)); load(mk(2)); load(mk(3));
    start(3'd0);
    chk("R9 level three", rd_data, 8'h03);
    nxt(); chk("R7 A X high", rd_data, 8'd1);
    nxt(); chk("R7 A X low", rd_data, 8'h14);
    nxt(); chk("R7 A Y high", rd_data, 8'd9);
    nxt(); chk("R7 A Y low", rd_data, 8'h00);
    nxt(); chk("R7 A Z high", rd_data, 8'd17);
    nxt(); chk("R7 A Z low", rd_data, 8'hFC);
    nxt(); chk("R7 pop then B X high", rd_data, 8'd2);
    start(3'd0);
    chk("R9 level after pop", rd_data, 8'h02);
    start(3'd4);
    chk("R6 addr 4 reads zero", rd_data, 8'h00);
    start(3'd2);
    chk("R6 addr 2 reads zero", rd_data, 8'h00);
    cfg_fast = 1'b1;
    start(3'd1);
    chk("R7 fast B X high", rd_data, 8'd2);
    nxt(); chk("R7 fast B Y high", rd_data, 8'd10);
    nxt(); chk("R7 fast B Z high", rd_data, 8'd18);
    nxt(); chk("R7 fast pop then C X high", rd_data, 8'd3);
    start(3'd0);
    chk("R9 level one", rd_data, 8'h01);

    // overflow: 33 pushes onto one entry -> two oldest dropped
    cfg_fast = 1'b0;
    for (int i = 10; i <= 42; i++) load(mk(i));
    start(3'd0);
    chk("R9 full with overflow flag", rd_data, 8'hA0);
    nxt(); chk("R9 oldest survivor X high", rd_data, 8'd11);
    nxt(); chk("R9 survivor X low", rd_data, 8'h14);
    nxt(); chk("R9 survivor Y high", rd_data, 8'd19);
    nxt(); nxt();
    chk("R9 survivor Z high", rd_data, 8'd27);
    nxt(); nxt();
    chk("R7 pop after overflow", rd_data, 8'd12);
    start(3'd0);
    chk("R9 flag cleared, level 31", rd_data, 8'h1F);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule